// File: doc/BRIEF.md
# 16-bit Integer Execution Unit

This block is the combinational arithmetic, logic and shift unit of a small 16-bit integer datapath. It receives two operands and a 4-bit operation select, and it returns one 16-bit result in the same cycle. The first operand is always the source register value. The second operand is either another register value or an immediate that has already been extended upstream.

Several operations are deliberately asymmetric. Subtraction computes the second operand minus the first. The logic operation clears, in the first operand, the bits that are set in the second operand. The set-on-condition operations return a 0/1 word. A whole-word bit reversal uses only the first operand.

The unit holds no state and has no clock or reset. Immediate extension, register access, memory and pipeline control are handled by the surrounding stages.

Top module: `exec_alu`

## Requirements
- R1: Select code 0 returns (A + B) modulo 2^16.
- R2: Select code 1 returns (B - A) modulo 2^16, the second operand minus the first.
- R3: Select code 2 returns A XOR B. Select code 3 returns A AND NOT B, which clears in A every bit that is set in B.
- R4: The shift amount is B[3:0], and B[15:4] has no effect on the result. The four shift codes are:
  - code 4: rotate left;
  - code 5: logical shift left, filling with zeros;
  - code 6: rotate right;
  - code 7: logical shift right, filling with zeros.
- R5: For each of codes 4 to 7, a shift amount of zero returns A unchanged.
- R6: The compare codes treat A and B as two's-complement numbers:
  - code 8: A equal to B;
  - code 9: A less than B;
  - code 10: A less than or equal to B.

  Each returns 0x0001 when the condition is true and 0x0000 when it is false.
- R7: Codes 9 and 10 give the correct signed answer even when A - B overflows 16 bits. For example, 0x8000 is less than 0x7FFF, and 0x7FFF is not less than or equal to 0x8000.
- R8: Select code 11 returns 0x0001 exactly when the unsigned sum A + B carries out of bit 15, and 0x0000 otherwise.
- R9: Select code 12 returns A with bit i moved to bit 15-i for every i. B has no effect on this result.
- R10: Select codes 13, 14 and 15 return 0x0000 for any operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation select, encoded as listed in the requirements |
| opnd_a | input | 16 | First operand (source register value) |
| opnd_b | input | 16 | Second operand (register value or pre-extended immediate) |
| result | output | 16 | Result of the selected operation |

## Verification
The bench builds the unit at the default data width of 16. At this width the 4-bit shift amount covers every position from 0 to 15, so each shift and rotate distance is reachable, including the zero distance and the wrap at full width. The sign-boundary values 0x7FFF and 0x8000 and the carry boundary 0xFFFF + 0x0001 are exercised exactly, and so is their overflow in the signed compares. Every select code, including the three unused ones, is crossed with a fixed grid of corner operands and then with seeded random operands.

// File: rtl/exec_alu_pkg.sv
// Package exec_alu_pkg
// Purpose: the operation-select encoding shared by the execution unit and its sub-blocks.
// Assumes: the select is 4 bits wide; codes 13 to 15 are unused and produce zero.
package exec_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_RSUB = 4'd1,
        OP_XOR  = 4'd2,
        OP_CLR  = 4'd3,
        OP_ROTL = 4'd4,
        OP_SHL  = 4'd5,
        OP_ROTR = 4'd6,
        OP_SHR  = 4'd7,
        OP_EQ   = 4'd8,
        OP_LT   = 4'd9,
        OP_LE   = 4'd10,
        OP_CRY  = 4'd11,
        OP_REV  = 4'd12
    } alu_op_e;

endpackage

// File: rtl/exec_alu_arith.sv
// Module exec_alu_arith
// Purpose: adder, reverse subtractor, signed comparator and carry-out detector.
// Assumes: operands are DATA_W-bit two's-complement values; purely combinational.
module exec_alu_arith #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] sum_o,
    output logic [DATA_W-1:0] rsub_o,
    output logic              eq_o,
    output logic              lt_o,
    output logic              le_o,
    output logic              cry_o
);

    localparam int EXT_W = DATA_W + 1;

    logic [EXT_W-1:0] sum_ext;
    logic [EXT_W-1:0] diff_ext;

    // Unsigned add with one extra bit, so the carry out of the top bit is kept.
    always_comb begin
        sum_ext = {1'b0, a_i} + {1'b0, b_i};
        sum_o   = sum_ext[DATA_W-1:0];
        cry_o   = sum_ext[DATA_W];
    end

    // Reverse subtraction: second operand minus first.
    always_comb begin
        rsub_o = b_i - a_i;
    end

    // Signed compare on sign-extended operands, so that A - B cannot overflow.
    always_comb begin
        diff_ext = {a_i[DATA_W-1], a_i} - {b_i[DATA_W-1], b_i};
        lt_o     = diff_ext[DATA_W];
        eq_o     = (a_i == b_i);
        le_o     = lt_o | eq_o;
    end

    // Checks on the arithmetic outputs, made once the operands are known.
    always_comb begin
        if (!$isunknown({a_i, b_i})) begin
            AST_CARRY_WRAP: assert (cry_o == (a_i > ~b_i)); // R8
            AST_RSUB_INVERSE: assert ((rsub_o + a_i) == b_i); // R2
            AST_EQ_LT_EXCL: assert (!(eq_o && lt_o)); // R6
            if (a_i[DATA_W-1] != b_i[DATA_W-1]) begin
                AST_LT_SIGN_SPLIT: assert (lt_o == a_i[DATA_W-1]); // R7
            end
        end
    end

endmodule

// File: rtl/exec_alu_shift.sv
// Module exec_alu_shift
// Purpose: log-depth barrel network for rotate left and right, and for logical shifts left and right.
// Assumes: DATA_W is a power of two; the amount is the low log2(DATA_W) bits of B.
module exec_alu_shift #(
    parameter int DATA_W = 16,
    parameter int AMT_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [AMT_W-1:0]  amt_i,
    output logic [DATA_W-1:0] rotl_o,
    output logic [DATA_W-1:0] shl_o,
    output logic [DATA_W-1:0] rotr_o,
    output logic [DATA_W-1:0] shr_o
);

    // Staged network: stage s moves the word by 2**s when amount bit s is set.
    always_comb begin
        rotl_o = a_i;
        shl_o  = a_i;
        rotr_o = a_i;
        shr_o  = a_i;
        for (int s = 0; s < AMT_W; s++) begin
            if (amt_i[s]) begin
                rotl_o = (rotl_o << (2 ** s)) | (rotl_o >> (DATA_W - 2 ** s));
                shl_o  = shl_o << (2 ** s);
                rotr_o = (rotr_o >> (2 ** s)) | (rotr_o << (DATA_W - 2 ** s));
                shr_o  = shr_o >> (2 ** s);
            end
        end
    end

    // Checks on the shift outputs, made once the inputs are known.
    always_comb begin
        if (!$isunknown({a_i, amt_i})) begin
            AST_ROT_KEEPS_ONES: assert ($countones(rotl_o) == $countones(a_i)
                                        && $countones(rotr_o) == $countones(a_i)); // R4
            if (amt_i == '0) begin
                AST_ZERO_AMT_PASS: assert (rotl_o == a_i && shl_o == a_i
                                           && rotr_o == a_i && shr_o == a_i); // R5
            end else begin
                AST_SHIFT_ZERO_FILL: assert (shr_o[DATA_W-1] == 1'b0 && shl_o[0] == 1'b0); // R4
            end
        end
    end

endmodule

// File: rtl/exec_alu_logic.sv
// Module exec_alu_logic
// Purpose: bitwise XOR, bit-clear (A AND NOT B) and whole-word bit reversal.
// Assumes: purely combinational; the reversal uses only operand A.
module exec_alu_logic #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] xor_o,
    output logic [DATA_W-1:0] clr_o,
    output logic [DATA_W-1:0] rev_o
);

    // Bitwise operations of the two operands.
    always_comb begin
        xor_o = a_i ^ b_i;
        clr_o = a_i & ~b_i;
    end

    // Mirror wiring: bit i of A lands in bit DATA_W-1-i.
    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        assign rev_o[i] = a_i[DATA_W-1-i];
    end

    // Checks on the logic outputs, made once the operands are known.
    always_comb begin
        if (!$isunknown({a_i, b_i})) begin
            AST_CLR_NO_B_BITS: assert ((clr_o & b_i) == '0 && (clr_o | a_i) == a_i); // R3
            AST_XOR_UNDO: assert ((xor_o ^ b_i) == a_i); // R3
            AST_REV_EDGES: assert (rev_o[0] == a_i[DATA_W-1] && rev_o[DATA_W-1] == a_i[0]
                                   && $countones(rev_o) == $countones(a_i)); // R9
        end
    end

endmodule

// File: rtl/exec_alu.sv
// Module exec_alu
// Purpose: top of the execution unit; runs the arithmetic, logic and shift sub-blocks
//          in parallel and selects one result by the operation code.
// Assumes: combinational, with no clock or reset; unused codes return zero.
module exec_alu #(
    parameter int DATA_W = 16
) (
    input  logic [3:0]        op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] result
);

    import exec_alu_pkg::*;

    localparam int AMT_W = $clog2(DATA_W);

    alu_op_e           op;
    logic [DATA_W-1:0] sum_v, rsub_v, xor_v, clr_v, rev_v;
    logic [DATA_W-1:0] rotl_v, shl_v, rotr_v, shr_v;
    logic              eq_v, lt_v, le_v, cry_v;

    assign op = alu_op_e'(op_sel);

    exec_alu_arith #(.DATA_W(DATA_W)) arith_i (
        .a_i    (opnd_a),
        .b_i    (opnd_b),
        .sum_o  (sum_v),
        .rsub_o (rsub_v),
        .eq_o   (eq_v),
        .lt_o   (lt_v),
        .le_o   (le_v),
        .cry_o  (cry_v)
    );

    exec_alu_shift #(.DATA_W(DATA_W), .AMT_W(AMT_W)) shift_i (
        .a_i    (opnd_a),
        .amt_i  (opnd_b[AMT_W-1:0]),
        .rotl_o (rotl_v),
        .shl_o  (shl_v),
        .rotr_o (rotr_v),
        .shr_o  (shr_v)
    );

    exec_alu_logic #(.DATA_W(DATA_W)) logic_i (
        .a_i   (opnd_a),
        .b_i   (opnd_b),
        .xor_o (xor_v),
        .clr_o (clr_v),
        .rev_o (rev_v)
    );

    // Result select; each flag is widened to a 0/1 word, and unused codes give zero.
    always_comb begin
        case (op)
            OP_ADD:  result = sum_v;
            OP_RSUB: result = rsub_v;
            OP_XOR:  result = xor_v;
            OP_CLR:  result = clr_v;
            OP_ROTL: result = rotl_v;
            OP_SHL:  result = shl_v;
            OP_ROTR: result = rotr_v;
            OP_SHR:  result = shr_v;
            OP_EQ:   result = {{(DATA_W-1){1'b0}}, eq_v};
            OP_LT:   result = {{(DATA_W-1){1'b0}}, lt_v};
            OP_LE:   result = {{(DATA_W-1){1'b0}}, le_v};
            OP_CRY:  result = {{(DATA_W-1){1'b0}}, cry_v};
            OP_REV:  result = rev_v;
            default: result = '0;
        endcase
    end

endmodule

// File: tb/exec_alu_tb_top.sv
// Bench exec_alu_tb_top
// Purpose: directed corners and seeded random operands for every select code,
//          each compared with an expected value computed by a bench function.
module exec_alu_tb_top;

    logic        clk = 1'b0;
    logic [3:0]  op_sel = 4'd15;
    logic [15:0] opnd_a = '0;
    logic [15:0] opnd_b = '0;
    logic [15:0] result;
    int          checks = 0;
    int          errors = 0;
    int          cycles = 0;
    logic        done = 1'b0;

    // 250 MHz clock.
    always #2 clk = ~clk;

    exec_alu #(.DATA_W(16)) dut_i (
        .op_sel (op_sel),
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .result (result)
    );

    // Expected result, built from the requirement text.
    function automatic logic [15:0] model(logic [3:0] op, logic [15:0] a, logic [15:0] b);
        logic [15:0] r;
        logic [16:0] s;
        int          n;
        r = '0;
        n = int'(b[3:0]);
        case (op)
            4'd0:  r = a + b;
            4'd1:  r = b - a;
            4'd2:  r = a ^ b;
            4'd3:  r = a & ~b;
            4'd4:  for (int i = 0; i < 16; i++) r[(i + n) % 16] = a[i];
            4'd5:  for (int i = 0; i < 16; i++) if (i + n < 16) r[i + n] = a[i];
            4'd6:  for (int i = 0; i < 16; i++) r[i] = a[(i + n) % 16];
            4'd7:  for (int i = 0; i < 16; i++) if (i + n < 16) r[i] = a[i + n];
            4'd8:  r = {15'd0, a == b};
            4'd9:  r = {15'd0, $signed(a) < $signed(b)};
            4'd10: r = {15'd0, $signed(a) <= $signed(b)};
            4'd11: begin s = {1'b0, a} + {1'b0, b}; r = {15'd0, s[16]}; end
            4'd12: for (int i = 0; i < 16; i++) r[15 - i] = a[i];
            default: r = '0;
        endcase
        return r;
    endfunction

    // Requirement tag for each select code.
    function automatic string req_of(logic [3:0] op);
        case (op)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2, 4'd3: return "R3";
            4'd4, 4'd5, 4'd6, 4'd7: return "R4";
            4'd8, 4'd9, 4'd10: return "R6";
            4'd11: return "R8";
            4'd12: return "R9";
            default: return "R10";
        endcase
    endfunction

    // Drive on the falling edge, sample on the next rising edge, compare with exp.
    task automatic run(input string req, input logic [3:0] op, input logic [15:0] a,
                       input logic [15:0] b, input logic [15:0] exp);
        @(negedge clk);
        op_sel = op;
        opnd_a = a;
        opnd_b = b;
        @(posedge clk);
        checks++;
        if (result !== exp) begin
            errors++;
            $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h", req, op, a, b, result, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failed check and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] corner [7];
        int unused_seed;
        corner[0] = 16'h0000; corner[1] = 16'h0001; corner[2] = 16'hFFFF;
        corner[3] = 16'h8000; corner[4] = 16'h7FFF; corner[5] = 16'h5555;
        corner[6] = 16'hAAAA;
        unused_seed = $urandom(32'd20240611);

        // Idle state: an unused code with zero operands gives zero (R10).
        run("R10", 4'd15, 16'h0000, 16'h0000, 16'h0000);

        // Directed corners.
        run("R1", 4'd0, 16'hFFFF, 16'h0001, 16'h0000);
        run("R2", 4'd1, 16'h0005, 16'h0003, 16'hFFFE);
        run("R3", 4'd3, 16'hF0F0, 16'hFF00, 16'h00F0);
        run("R3", 4'd2, 16'hF0F0, 16'hFF00, 16'h0FF0);
        run("R4", 4'd5, 16'h0001, 16'hFFF3, 16'h0008);
        run("R4", 4'd4, 16'h8001, 16'h0011, 16'h0003);
        run("R4", 4'd6, 16'h0001, 16'h0001, 16'h8000);
        run("R4", 4'd7, 16'h8000, 16'h000F, 16'h0001);
        run("R5", 4'd4, 16'h1234, 16'hFFF0, 16'h1234);
        run("R5", 4'd5, 16'h1234, 16'h0000, 16'h1234);
        run("R5", 4'd6, 16'h1234, 16'h0010, 16'h1234);
        run("R5", 4'd7, 16'h1234, 16'h0000, 16'h1234);
        run("R6", 4'd8, 16'h1234, 16'h1234, 16'h0001);
        run("R6", 4'd9, 16'hFFFF, 16'h0000, 16'h0001);
        run("R6", 4'd10, 16'h0003, 16'h0003, 16'h0001);
        run("R7", 4'd9, 16'h8000, 16'h7FFF, 16'h0001);
        run("R7", 4'd10, 16'h7FFF, 16'h8000, 16'h0000);
        run("R7", 4'd9, 16'h7FFF, 16'h8000, 16'h0000);
        run("R8", 4'd11, 16'hFFFF, 16'h0001, 16'h0001);
        run("R8", 4'd11, 16'hFFFE, 16'h0001, 16'h0000);
        run("R9", 4'd12, 16'h0001, 16'h0000, 16'h8000);
        run("R9", 4'd12, 16'h0001, 16'hFFFF, 16'h8000);
        run("R10", 4'd13, 16'hFFFF, 16'hFFFF, 16'h0000);
        run("R10", 4'd14, 16'h8000, 16'h7FFF, 16'h0000);
        run("R10", 4'd15, 16'hFFFF, 16'h0001, 16'h0000);

        // Every code crossed with every pair of corner operands.
        for (int op = 0; op < 16; op++) begin
            for (int i = 0; i < 7; i++) begin
                for (int j = 0; j < 7; j++) begin
                    run(req_of(4'(op)), 4'(op), corner[i], corner[j],
                        model(4'(op), corner[i], corner[j]));
                end
            end
        end

        // Seeded random operands over all codes.
        for (int k = 0; k < 3000; k++) begin
            logic [3:0]  op;
            logic [15:0] a;
            logic [15:0] b;
            op = 4'($urandom_range(0, 15));
            a  = 16'($urandom);
            b  = 16'($urandom);
            run(req_of(op), op, a, b, model(op, a, b));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule